// File: doc/BRIEF.md
# Integer ALU with Half-Word Immediate Placement

This is the execution stage of a small RISC core. Each issued operation takes a first operand and either a second register operand or a 16-bit constant. A 3-bit operation code selects one of eight functions: add, add-with-carry, subtract, subtract-with-borrow, AND, OR, XOR or shift. The unit returns a registered 32-bit result one clock later. It also holds a four-flag status word (carry, overflow, zero, negative). Only operations that ask for it update the status word.

A constant can sit in either half of the word. For AND, the uncovered half becomes all ones, so a constant can mask one half and leave the other half intact. For every other operation the uncovered half is zero. Shifts take a signed amount: a positive value shifts left and a negative value shifts right. Each operand comes with its register index. Two reserved indices replace the supplied value with a constant: one with zero and one with all ones. A constant can therefore be loaded with an add to the zero register or an AND with the all-ones register.

Top module: `alu_exec`

## Requirements
- R1: When `issue` is high on a rising clock edge, `res` shows the operation's result after that edge and `res_valid` is high for exactly that cycle. When `issue` is low, `res` holds its value and `res_valid` is low.
- R2: The `op` codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 shift.
- R3: When `imm_form` is 1 and `op` is not 7, `half_sel`=0 places `imm16` in bits 15:0 and `half_sel`=1 places it in bits 31:16.
- R4: For AND with a constant, the half not covered by `imm16` is all ones. For add, subtract, OR and XOR with a constant, that half is zeros.
- R5: `status` changes only on an edge where both `issue` and `flag_en` are 1. Otherwise it keeps its value.
- R6: Add-with-carry adds `status[0]` as carry-in. Subtract-with-borrow computes a + ~b + `status[0]`. Plain subtract computes a + ~b + 1.
- R7: For arithmetic operations, the carry flag is the carry out of the 33-bit sum, so for subtraction 1 means no borrow. Overflow is the signed overflow of that sum.
- R8: The status bits are: bit 0 carry, bit 1 overflow, bit 2 zero (result is 0), bit 3 negative (result bit 31). For AND, OR and XOR, carry and overflow become 0. For shifts, overflow becomes 0.
- R9: For a shift in constant form, the amount is `imm16[5:0]` read as a signed number and the constant is never moved to the upper half. Here `half_sel`=0 selects a logical shift and `half_sel`=1 an arithmetic shift.
- R10: For a shift in register form, the amount is bit 5:0 of the second operand read as signed. `func`=5'b11000 selects an arithmetic shift and any other value a logical shift.
- R11: A positive amount shifts left and a negative amount shifts right by its magnitude, up to 32. When flags are enabled, the carry takes the last bit shifted out. An amount of zero leaves the operand unchanged and clears the carry.
- R12: An operand index of 0 reads as zero and an index of 1 reads as all ones, whatever value is supplied with it.
- R13: After reset, `res`=0, `res_valid`=0 and `status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation code |
| imm_form | input | 1 | 1: second operand is `imm16`; 0: second operand is the register |
| half_sel | input | 1 | Constant half select, or shift kind in constant form |
| flag_en | input | 1 | Write the status word |
| func | input | 5 | Function field for register-form shifts |
| a_idx | input | 5 | Register index of the first operand |
| a_val | input | 32 | Value read for the first operand |
| b_idx | input | 5 | Register index of the second operand |
| b_val | input | 32 | Value read for the second operand |
| imm16 | input | 16 | Constant field |
| res_valid | output | 1 | Result registered on the last edge |
| res | output | 32 | Registered result |
| status | output | 4 | Flags {negative, zero, overflow, carry} |

## Verification
The bench builds the unit with a 32-bit data path, a 16-bit constant and the staged barrel shifter. These widths make the carry, overflow and sign corners reachable at 0x7FFFFFFF and 0xFFFFFFFF, and they make a right shift by the full 32 places reachable through a register amount of -32. A scoreboard model, written independently and shifting one bit at a time, tracks the expected status word across operations. This shows that carry survives operations with flags disabled and then feeds add-with-carry and subtract-with-borrow. Idle cycles with flag writes requested show that nothing changes unless an operation is issued.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

   typedef enum logic [2:0] {
      OP_ADD   = 3'd0,
      OP_ADDC  = 3'd1,
      OP_SUB   = 3'd2,
      OP_SUBB  = 3'd3,
      OP_AND   = 3'd4,
      OP_OR    = 3'd5,
      OP_XOR   = 3'd6,
      OP_SHIFT = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic neg;
      logic zero;
      logic ovf;
      logic carry;
   } alu_flags_t;

   localparam int FUNC_W = 5;
   localparam logic [FUNC_W-1:0] FN_SHIFT_ARITH = 5'b11000;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 16,
   parameter int REG_IDX_W = 5,
   parameter int ZERO_REG  = 0,
   parameter int ONES_REG  = 1
) (
   input  logic [REG_IDX_W-1:0] a_idx,
   input  logic [DATA_W-1:0]    a_val,
   input  logic [REG_IDX_W-1:0] b_idx,
   input  logic [DATA_W-1:0]    b_val,
   input  logic                 imm_form,
   input  logic                 place_hi,
   input  logic                 fill_ones,
   input  logic [IMM_W-1:0]     imm,
   output logic [DATA_W-1:0]    opa,
   output logic [DATA_W-1:0]    opb
);
   localparam int REST_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] b_reg;
   logic [DATA_W-1:0] b_const;
   logic [REST_W-1:0] rest_fill;

   function automatic logic [DATA_W-1:0] read_port(input logic [REG_IDX_W-1:0] idx,
                                                   input logic [DATA_W-1:0] val);
      if (idx == REG_IDX_W'(ZERO_REG))      return '0;
      else if (idx == REG_IDX_W'(ONES_REG)) return '1;
      else                                  return val;
   endfunction

   assign opa       = read_port(a_idx, a_val);
   assign b_reg     = read_port(b_idx, b_val);
   assign rest_fill = fill_ones ? '1 : '0;

   generate
      if (REST_W > 0) begin : g_split
         assign b_const = place_hi ? {imm, rest_fill} : {rest_fill, imm};
      end else begin : g_full
         assign b_const = imm;
      end
   endgenerate

   assign opb = imm_form ? b_const : b_reg;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              invert_b,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;

   assign b_eff = invert_b ? ~b : b;
   assign wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
   assign sum   = wide[DATA_W-1:0];
   assign cout  = wide[DATA_W];
   assign ovf   = (a[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int DATA_W = 32,
   parameter int SA_W   = 6,
   parameter bit BARREL = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [SA_W-1:0]   amt,
   input  logic              arith,
   output logic [DATA_W-1:0] res,
   output logic              cout
);
   logic            go_right;
   logic [SA_W-1:0] mag;
   logic            fill;
   logic [DATA_W:0] left_v;
   logic [DATA_W:0] right_v;

   assign go_right = amt[SA_W-1];
   assign mag      = go_right ? (~amt + 1'b1) : amt;
   assign fill     = arith & a[DATA_W-1];

   generate
      if (BARREL) begin : g_barrel
         logic [DATA_W:0] lst [0:SA_W];
         logic [DATA_W:0] rst_v [0:SA_W];
         assign lst[0]   = {1'b0, a};
         assign rst_v[0] = {a, 1'b0};
         for (genvar i = 0; i < SA_W; i++) begin : g_stage
            localparam int K = 1 << i;
            if (K <= DATA_W) begin : g_live
               assign lst[i+1]   = mag[i] ? {lst[i][DATA_W-K:0], {K{1'b0}}} : lst[i];
               assign rst_v[i+1] = mag[i] ? {{K{fill}}, rst_v[i][DATA_W:K]} : rst_v[i];
            end else begin : g_pass
               assign lst[i+1]   = mag[i] ? '0 : lst[i];
               assign rst_v[i+1] = mag[i] ? {(DATA_W+1){fill}} : rst_v[i];
            end
         end
         assign left_v  = lst[SA_W];
         assign right_v = rst_v[SA_W];
      end else begin : g_behav
         logic [DATA_W:0] r_ext;
         assign r_ext   = {a, 1'b0};
         assign left_v  = {1'b0, a} << mag;
         assign right_v = arith ? ($signed(r_ext) >>> mag) : (r_ext >> mag);
      end
   endgenerate

   assign res  = go_right ? right_v[DATA_W:1] : left_v[DATA_W-1:0];
   assign cout = go_right ? right_v[0] : left_v[DATA_W];
endmodule

// File: rtl/alu_exec.sv
module alu_exec
   import alu_exec_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int IMM_W        = 16,
   parameter int REG_IDX_W    = 5,
   parameter int ZERO_REG     = 0,
   parameter int ONES_REG     = 1,
   parameter bit SHIFT_BARREL = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue,
   input  logic [2:0]           op,
   input  logic                 imm_form,
   input  logic                 half_sel,
   input  logic                 flag_en,
   input  logic [FUNC_W-1:0]    func,
   input  logic [REG_IDX_W-1:0] a_idx,
   input  logic [DATA_W-1:0]    a_val,
   input  logic [REG_IDX_W-1:0] b_idx,
   input  logic [DATA_W-1:0]    b_val,
   input  logic [IMM_W-1:0]     imm16,
   output logic                 res_valid,
   output logic [DATA_W-1:0]    res,
   output logic [3:0]           status
);
   localparam int SA_W = $clog2(DATA_W) + 1;

   generate
      if (IMM_W > DATA_W) begin : g_bad_imm
         $error("alu_exec: IMM_W must not exceed DATA_W");
      end
      if (IMM_W < SA_W) begin : g_bad_amt
         $error("alu_exec: IMM_W too narrow for a shift amount");
      end
      if ((1 << $clog2(DATA_W)) != DATA_W) begin : g_bad_w
         $error("alu_exec: DATA_W must be a power of two");
      end
      if (ZERO_REG == ONES_REG) begin : g_bad_reg
         $error("alu_exec: constant registers must differ");
      end
      if (ZERO_REG >= (1 << REG_IDX_W) || ONES_REG >= (1 << REG_IDX_W)) begin : g_bad_idx
         $error("alu_exec: constant register index out of range");
      end
   endgenerate

   alu_op_e           op_e;
   logic              is_shift;
   logic              is_and;
   logic              place_hi;
   logic [DATA_W-1:0] opa;
   logic [DATA_W-1:0] opb;
   alu_flags_t        flags_q;
   alu_flags_t        flags_d;
   logic [DATA_W-1:0] result_d;
   logic [DATA_W-1:0] res_q;
   logic              valid_q;

   assign op_e     = alu_op_e'(op);
   assign is_shift = (op_e == OP_SHIFT);
   assign is_and   = (op_e == OP_AND);
   assign place_hi = half_sel & ~is_shift;

   alu_operand_prep #(
      .DATA_W   (DATA_W),
      .IMM_W    (IMM_W),
      .REG_IDX_W(REG_IDX_W),
      .ZERO_REG (ZERO_REG),
      .ONES_REG (ONES_REG)
   ) u_prep (
      .a_idx    (a_idx),
      .a_val    (a_val),
      .b_idx    (b_idx),
      .b_val    (b_val),
      .imm_form (imm_form),
      .place_hi (place_hi),
      .fill_ones(is_and),
      .imm      (imm16),
      .opa      (opa),
      .opb      (opb)
   );

   logic              do_sub;
   logic              use_flag_c;
   logic              add_cin;
   logic [DATA_W-1:0] add_sum;
   logic              add_cout;
   logic              add_ovf;

   assign do_sub     = (op_e == OP_SUB) || (op_e == OP_SUBB);
   assign use_flag_c = (op_e == OP_ADDC) || (op_e == OP_SUBB);
   assign add_cin    = use_flag_c ? flags_q.carry : do_sub;

   alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a       (opa),
      .b       (opb),
      .invert_b(do_sub),
      .cin     (add_cin),
      .sum     (add_sum),
      .cout    (add_cout),
      .ovf     (add_ovf)
   );

   logic              sh_arith;
   logic [DATA_W-1:0] sh_res;
   logic              sh_cout;

   assign sh_arith = imm_form ? half_sel : (func == FN_SHIFT_ARITH);

   alu_shifter #(
      .DATA_W(DATA_W),
      .SA_W  (SA_W),
      .BARREL(SHIFT_BARREL)
   ) u_shift (
      .a    (opa),
      .amt  (opb[SA_W-1:0]),
      .arith(sh_arith),
      .res  (sh_res),
      .cout (sh_cout)
   );

   always_comb begin
      flags_d = '0;
      unique case (op_e)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
            result_d      = add_sum;
            flags_d.carry = add_cout;
            flags_d.ovf   = add_ovf;
         end
         OP_AND:  result_d = opa & opb;
         OP_OR:   result_d = opa | opb;
         OP_XOR:  result_d = opa ^ opb;
         default: begin
            result_d      = sh_res;
            flags_d.carry = sh_cout;
         end
      endcase
      flags_d.zero = (result_d == '0);
      flags_d.neg  = result_d[DATA_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         valid_q <= 1'b0;
         flags_q <= '0;
      end else begin
         valid_q <= issue;
         if (issue) begin
            res_q <= result_d;
            if (flag_en) begin
               flags_q <= flags_d;
            end
         end
      end
   end

   assign res       = res_q;
   assign res_valid = valid_q;
   assign status    = flags_q;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 16,
   parameter int REG_IDX_W = 5,
   parameter int ZERO_REG  = 0,
   parameter int ONES_REG  = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 issue,
   input logic [2:0]           op,
   input logic                 imm_form,
   input logic                 flag_en,
   input logic [REG_IDX_W-1:0] a_idx,
   input logic [DATA_W-1:0]    a_val,
   input logic [REG_IDX_W-1:0] b_idx,
   input logic [IMM_W-1:0]     imm16,
   input logic                 res_valid,
   input logic [DATA_W-1:0]    res,
   input logic [3:0]           status
);
   localparam int SA_W = $clog2(DATA_W) + 1;

   // R1: valid follows issue by one edge
   p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> res_valid);
   p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> !res_valid);
   // R1: result holds when idle
   p_res_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> $stable(res));
   // R5: status untouched unless flags written
   p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue && flag_en) |=> $stable(status));
   // R8: zero and negative flags agree with the stored result
   p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && flag_en) |=> (status[2] == (res == '0)));
   p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && flag_en) |=> (status[3] == res[DATA_W-1]));
   // R8: logic operations clear carry and overflow
   p_logic_cv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && flag_en && op[2] && (op != 3'd7)) |=> (status[1:0] == 2'b00));
   // R8: shifts clear overflow
   p_shift_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && flag_en && (op == 3'd7)) |=> !status[1]);
   // R11: zero amount passes operand through, carry cleared
   p_shift_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (op == 3'd7) && imm_form && (imm16[SA_W-1:0] == '0)
       && (a_idx != REG_IDX_W'(ZERO_REG)) && (a_idx != REG_IDX_W'(ONES_REG)))
      |=> (res == $past(a_val)));
   p_shift_zero_c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && flag_en && (op == 3'd7) && imm_form && (imm16[SA_W-1:0] == '0))
      |=> !status[0]);
   // R12: OR of the zero register with itself yields zero
   p_zero_reg_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !imm_form && (op == 3'd5) && (a_idx == REG_IDX_W'(ZERO_REG))
       && (b_idx == REG_IDX_W'(ZERO_REG))) |=> (res == '0));
endmodule

bind alu_exec alu_exec_chk #(
   .DATA_W   (DATA_W),
   .IMM_W    (IMM_W),
   .REG_IDX_W(REG_IDX_W),
   .ZERO_REG (ZERO_REG),
   .ONES_REG (ONES_REG)
) u_alu_exec_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .issue    (issue),
   .op       (op),
   .imm_form (imm_form),
   .flag_en  (flag_en),
   .a_idx    (a_idx),
   .a_val    (a_val),
   .b_idx    (b_idx),
   .imm16    (imm16),
   .res_valid(res_valid),
   .res      (res),
   .status   (status)
);

// File: tb/test_alu_exec.sv
module test_alu_exec;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [2:0]  op = '0;
   logic        imm_form = 1'b0;
   logic        half_sel = 1'b0;
   logic        flag_en = 1'b0;
   logic [4:0]  func = '0;
   logic [4:0]  a_idx = 5'd5;
   logic [31:0] a_val = '0;
   logic [4:0]  b_idx = 5'd6;
   logic [31:0] b_val = '0;
   logic [15:0] imm16 = '0;
   logic        res_valid;
   logic [31:0] res;
   logic [3:0]  status;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [31:0] exp_res_q [$];
   logic [3:0]  exp_st_q [$];
   string       tag_q [$];
   logic [3:0]  model_st = '0;
   logic [31:0] model_res = '0;

   always #(CLK_P/2) clk = ~clk;

   alu_exec #(
      .DATA_W(32), .IMM_W(16), .REG_IDX_W(5),
      .ZERO_REG(0), .ONES_REG(1), .SHIFT_BARREL(1'b1)
   ) i_alu_exec (
      .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .imm_form(imm_form),
      .half_sel(half_sel), .flag_en(flag_en), .func(func), .a_idx(a_idx),
      .a_val(a_val), .b_idx(b_idx), .b_val(b_val), .imm16(imm16),
      .res_valid(res_valid), .res(res), .status(status)
   );

   function automatic logic [31:0] rd(input logic [4:0] idx, input logic [31:0] v);
      if (idx == 5'd0) return 32'h0;
      if (idx == 5'd1) return 32'hFFFF_FFFF;
      return v;
   endfunction

   task automatic model(input logic [2:0] o, input logic imf, input logic hs,
                        input logic fen, input logic [4:0] fn,
                        input logic [31:0] a, input logic [31:0] br,
                        input logic [15:0] im);
      logic [31:0] b;
      logic [31:0] bx;
      logic [32:0] w;
      logic [31:0] r;
      logic c, v, ar;
      logic [5:0] amt;
      int n;
      c = 1'b0;
      v = 1'b0;
      if (!imf) b = br;
      else if (o == 3'd7) b = {16'h0, im};
      else if (hs) b = {im, (o == 3'd4) ? 16'hFFFF : 16'h0000};
      else b = {(o == 3'd4) ? 16'hFFFF : 16'h0000, im};
      if (o <= 3'd3) begin
         bx = (o >= 3'd2) ? ~b : b;
         w = {1'b0, a} + {1'b0, bx} +
             ((o == 3'd0) ? 33'd0 : (o == 3'd2) ? 33'd1 : {32'd0, model_st[0]});
         r = w[31:0];
         c = w[32];
         v = (a[31] == bx[31]) && (r[31] != a[31]);
      end else if (o == 3'd4) r = a & b;
      else if (o == 3'd5) r = a | b;
      else if (o == 3'd6) r = a ^ b;
      else begin
         ar  = imf ? hs : (fn == 5'b11000);
         amt = b[5:0];
         n   = amt[5] ? (64 - int'(amt)) : int'(amt);
         r   = a;
         for (int k = 0; k < n; k++) begin
            if (!amt[5]) begin
               c = r[31];
               r = {r[30:0], 1'b0};
            end else begin
               c = r[0];
               r = {ar ? r[31] : 1'b0, r[31:1]};
            end
         end
      end
      model_res = r;
      if (fen) model_st = {r[31], (r == 32'h0), v, c};
   endtask

   task automatic drive(input string tag, input logic [2:0] o, input logic imf,
                        input logic hs, input logic fen, input logic [4:0] fn,
                        input logic [4:0] ai, input logic [31:0] av,
                        input logic [4:0] bi, input logic [31:0] bv,
                        input logic [15:0] im);
      @(negedge clk);
      issue = 1'b1; op = o; imm_form = imf; half_sel = hs; flag_en = fen;
      func = fn; a_idx = ai; a_val = av; b_idx = bi; b_val = bv; imm16 = im;
      model(o, imf, hs, fen, fn, rd(ai, av), rd(bi, bv), im);
      exp_res_q.push_back(model_res);
      exp_st_q.push_back(model_st);
      tag_q.push_back(tag);
   endtask

   task automatic rr(input string tag, input logic [2:0] o, input logic fen,
                     input logic [4:0] fn, input logic [31:0] av, input logic [31:0] bv);
      drive(tag, o, 1'b0, 1'b0, fen, fn, 5'd5, av, 5'd6, bv, 16'h0);
   endtask

   task automatic ri(input string tag, input logic [2:0] o, input logic hs,
                     input logic fen, input logic [31:0] av, input logic [15:0] im);
      drive(tag, o, 1'b1, hs, fen, 5'd0, 5'd5, av, 5'd6, 32'hDEAD_BEEF, im);
   endtask

   task automatic idle_check(input int cycles);
      logic [31:0] r0;
      logic [3:0] s0;
      @(negedge clk);
      issue = 1'b0; flag_en = 1'b1; op = 3'd0; imm_form = 1'b0;
      a_idx = 5'd5; a_val = 32'h1234_5678; b_idx = 5'd6; b_val = 32'h1;
      @(negedge clk);
      r0 = res;
      s0 = status;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         total++;
         if (res_valid !== 1'b0 || res !== r0 || status !== s0) begin
            bad++;
            $display("FAIL R1/R5 idle: valid=%b res=%h st=%h expected valid=0 res=%h st=%h",
                     res_valid, res, status, r0, s0);
         end
      end
   endtask

   // monitor: pops the scoreboard when a result appears
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && res_valid) begin
            total++;
            if (exp_res_q.size() == 0) begin
               bad++;
               $display("FAIL R1 unexpected result: res=%h expected no result", res);
            end else begin
               logic [31:0] er;
               logic [3:0]  es;
               string       t;
               er = exp_res_q.pop_front();
               es = exp_st_q.pop_front();
               t  = tag_q.pop_front();
               if (res !== er || status !== es) begin
                  bad++;
                  $display("FAIL %s: res=%h status=%h expected res=%h status=%h",
                           t, res, status, er, es);
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if (res !== 32'h0 || res_valid !== 1'b0 || status !== 4'h0) begin
         bad++;
         $display("FAIL R13 reset: res=%h valid=%b st=%h expected 0 0 0", res, res_valid, status);
      end
      rst_n = 1'b1;

      rr("R2 R7 add basic", 3'd0, 1'b1, 5'd0, 32'd5, 32'd7);
      rr("R7 sub borrow", 3'd2, 1'b1, 5'd0, 32'd3, 32'd5);
      rr("R7 sub no borrow", 3'd2, 1'b1, 5'd0, 32'd5, 32'd3);
      rr("R7 R8 add signed overflow", 3'd0, 1'b1, 5'd0, 32'h7FFF_FFFF, 32'd1);
      rr("R7 R8 add carry zero", 3'd0, 1'b1, 5'd0, 32'hFFFF_FFFF, 32'd1);
      rr("R5 add without flags", 3'd0, 1'b0, 5'd0, 32'd10, 32'd20);
      rr("R6 addc carry in set", 3'd1, 1'b1, 5'd0, 32'd100, 32'd200);
      rr("R6 addc carry in clear", 3'd1, 1'b1, 5'd0, 32'd100, 32'd200);
      rr("R6 subb no carry", 3'd3, 1'b1, 5'd0, 32'd50, 32'd20);
      rr("R6 subb carry set", 3'd3, 1'b1, 5'd0, 32'd50, 32'd20);
      rr("R2 xor reg", 3'd6, 1'b1, 5'd0, 32'hF0F0_1234, 32'h0FF0_FFFF);
      ri("R3 R4 and const low", 3'd4, 1'b0, 1'b1, 32'h1234_5678, 16'h00FF);
      ri("R3 R4 and const high", 3'd4, 1'b1, 1'b1, 32'h1234_5678, 16'h0F0F);
      ri("R3 R4 or const high", 3'd5, 1'b1, 1'b0, 32'h0000_00AA, 16'hAB00);
      ri("R3 R4 xor const low", 3'd6, 1'b0, 1'b1, 32'hFFFF_0000, 16'h5555);
      ri("R3 R4 add const high", 3'd0, 1'b1, 1'b1, 32'h0000_0001, 16'h8000);
      ri("R9 R11 shift left 4", 3'd7, 1'b0, 1'b1, 32'h9000_000F, 16'h0004);
      ri("R9 R11 shift right logical 4", 3'd7, 1'b0, 1'b1, 32'h8000_0018, 16'h003C);
      ri("R9 R11 shift right arith 4", 3'd7, 1'b1, 1'b1, 32'h8000_0018, 16'hFFFC);
      ri("R9 R11 shift right arith 31", 3'd7, 1'b1, 1'b1, 32'h4000_0000, 16'h0021);
      ri("R11 shift zero amount", 3'd7, 1'b1, 1'b1, 32'hC001_0003, 16'h0000);
      rr("R10 R11 reg shift left", 3'd7, 1'b1, 5'b10000, 32'h0000_0003, 32'd31);
      rr("R10 R11 reg shift logical -32", 3'd7, 1'b1, 5'b10000, 32'h8000_0001, 32'hFFFF_FFE0);
      rr("R10 R11 reg shift arith -32", 3'd7, 1'b1, 5'b11000, 32'h8000_0001, 32'hFFFF_FFE0);
      rr("R10 reg shift arith -1", 3'd7, 1'b1, 5'b11000, 32'hF000_0001, 32'hFFFF_FFFF);
      drive("R12 and ones reg const load", 3'd4, 1'b1, 1'b0, 1'b1, 5'd0,
            5'd1, 32'h0BAD_0BAD, 5'd6, 32'h0, 16'h1234);
      drive("R12 add zero reg operand b", 3'd0, 1'b0, 1'b0, 1'b1, 5'd0,
            5'd7, 32'h0000_4321, 5'd0, 32'hFFFF_FFFF, 16'h0);
      drive("R12 or zero regs", 3'd5, 1'b0, 1'b0, 1'b1, 5'd0,
            5'd0, 32'h1111_1111, 5'd0, 32'h2222_2222, 16'h0);
      drive("R12 xor ones reg operand b", 3'd6, 1'b0, 1'b0, 1'b0, 5'd0,
            5'd9, 32'h0F0F_0F0F, 5'd1, 32'h0, 16'h0);

      idle_check(4);

      rr("R1 after idle sub", 3'd2, 1'b1, 5'd0, 32'h8000_0000, 32'd1);
      @(negedge clk);
      issue = 1'b0;
      repeat (3) @(negedge clk);
      total++;
      if (exp_res_q.size() != 0) begin
         bad++;
         $display("FAIL R1 missing results: pending=%0d expected 0", exp_res_q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule